// File: doc/BRIEF.md
# System-Control Coprocessor Register Access Unit

This block sits beside a processor core and serves coprocessor register-transfer instructions aimed at the system-control coprocessor, which is coprocessor number 15. It recognises the instruction pattern and checks the processor mode and the addressed register number. It then either performs a register read, performs a register write, raises the undefined-instruction trap, or retires the instruction as a no-op. The stored registers hold the configuration for the cache, the write buffer and the memory-management unit. Their contents are driven out continuously so that those units can use them.

The core evaluates the condition code and reports the result on `cond_pass`. The acceptance decision, the trap and the write enables are combinational and appear in the cycle the instruction is presented. Register contents and the read result change at the following clock edge. A write to one of the two flush registers stores nothing. Instead it produces a one-cycle strobe that the cache or the translation logic can act on. The cache, the MMU and the table-walk logic are outside this block.

Top module: `sysctl_xfer_unit`

## Requirements
- R1: `accept` is high only when `insn_valid` is high, bits 27:24 are 1110, bits 11:8 are 1111 and bit 4 is 1. Any other word leaves `accept`, `undef_trap`, `cfg_wr_en`, `rd_valid` and both strobes low, and changes no register.
- R2: In an accepted instruction, bit 20 = 1 means a read (coprocessor register to core register) and bit 20 = 0 means a write. The register number is taken from bits 19:16 and the core register index from bits 15:12.
- R3: An accepted instruction with a passing condition and `priv_mode` = 0 (user mode) raises `undef_trap` and changes no register.
- R4: An accepted instruction with a passing condition that addresses register 8 to 15 raises `undef_trap` in any mode.
- R5: Register 4 is invalid. A privileged access to it raises no trap, gives no `rd_valid`, produces no write enable and no strobe, and changes no register.
- R6: Written data is masked before it is stored. Register 1 keeps only bits 8:0, register 2 keeps only bits 31:14, register 3 keeps all 32 bits and register 6 keeps only bits 31:12. All other bits read back as zero.
- R7: A read of register 0 returns the `ID_WORD` constant. A write to register 0 has no effect.
- R8: A privileged write to register 5 pulses `tlb_flush`, and one to register 7 pulses `cache_flush`. Each pulse lasts exactly the cycle after the accept cycle. Neither register stores data, and a read of either returns zero.
- R9: When `cond_pass` = 0, an accepted instruction is a no-op. There is no trap, no write, no read result and no strobe.
- R10: After reset, all stored registers are zero, so the cache, the write buffer and the MMU come up disabled. `rd_valid`, `tlb_flush` and `cache_flush` are low after reset.
- R11: For a privileged read of a valid register, `rd_valid` is high in the cycle after the accept cycle. In that cycle `rd_data` holds the register value and `rd_dest` holds bits 15:12 of the instruction.
- R12: For a privileged write to register n, where n is 1, 2, 3 or 6, bit n of `cfg_wr_en` is high during the accept cycle and the other bits are low. The new value appears on the register outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition code of the instruction passed |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| wr_data | input | 32 | Core register value for writes |
| accept | output | 1 | Instruction claimed by this block |
| undef_trap | output | 1 | Undefined-instruction trap request |
| cfg_wr_en | output | 8 | Per-register write enable, indexed by register number |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| rd_dest | output | 4 | Core register index for the read result |
| tlb_flush | output | 1 | Translation flush strobe |
| cache_flush | output | 1 | Cache flush strobe |
| ctl_q | output | 32 | Register 1: cache, write buffer and MMU enables |
| tbase_q | output | 32 | Register 2: translation table base |
| dom_q | output | 32 | Register 3: domain access control |
| fault_q | output | 32 | Register 6: fault address |

## Verification
Random instruction words mix the correct pattern with words that have a wrong coprocessor number or a clear bit 4, which tests acceptance against claiming foreign instructions. Register numbers cover the whole range 0 to 15, and mode and condition vary independently. This shows that a user-mode trap, a high-number trap, the silent register-4 no-op and a failed condition each come out differently. All-ones and alternating data written to every register and read back expose wrong reserved-bit masks. Directed writes to registers 0, 5 and 7 check that a write to an identity or strobe register is never mistaken for a store.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 8;
  localparam int RIDX_W = 4;

  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_QUIET = 3'd1,
    ACT_TRAP  = 3'd2,
    ACT_READ  = 3'd3,
    ACT_WRITE = 3'd4
  } act_e;

  typedef struct packed {
    logic              dir_rd;
    logic [RIDX_W-1:0] crn;
    logic [RIDX_W-1:0] core_idx;
  } xfer_t;

  // Instruction shape recognised as a transfer to coprocessor 15.
  function automatic logic is_sysctl_xfer(input logic [XLEN-1:0] w);
    return (w[27:24] == 4'b1110) && (w[11:8] == 4'b1111) && w[4];
  endfunction

  function automatic xfer_t split_fields(input logic [XLEN-1:0] w);
    xfer_t f;
    f.dir_rd   = w[20];
    f.crn      = w[19:16];
    f.core_idx = w[15:12];
    return f;
  endfunction

  // Register numbers 0..7 that respond; 4 is a hole.
  function automatic logic reg_known(input logic [RIDX_W-1:0] n);
    return (n[3] == 1'b0) && (n != 4'd4);
  endfunction

  // Registers that keep written data.
  function automatic logic reg_holds(input logic [RIDX_W-1:0] n);
    return (n == 4'd1) || (n == 4'd2) || (n == 4'd3) || (n == 4'd6);
  endfunction

  // Bits kept on write; everything else is stored as zero.
  function automatic logic [XLEN-1:0] keep_bits(input logic [RIDX_W-1:0] n);
    logic [XLEN-1:0] m;
    case (n)
      4'd1:    m = {{(XLEN-9){1'b0}}, 9'h1FF};
      4'd2:    m = {{(XLEN-14){1'b1}}, 14'h0};
      4'd3:    m = '1;
      4'd6:    m = {{(XLEN-12){1'b1}}, 12'h0};
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic              insn_valid,
  input  logic [XLEN-1:0]   insn,
  input  logic              cond_pass,
  input  logic              priv_mode,
  output logic              claim,
  output act_e              act,
  output logic [RIDX_W-1:0] crn,
  output logic [RIDX_W-1:0] core_idx
);

  xfer_t f;

  always_comb begin
    f        = split_fields(insn);
    crn      = f.crn;
    core_idx = f.core_idx;
    claim    = insn_valid && is_sysctl_xfer(insn);
    if (!claim)
      act = ACT_IDLE;
    else if (!cond_pass)
      act = ACT_QUIET;
    else if (!priv_mode || f.crn[3])
      act = ACT_TRAP;
    else if (!reg_known(f.crn))
      act = ACT_QUIET;
    else if (f.dir_rd)
      act = ACT_READ;
    else
      act = ACT_WRITE;
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] ID_WORD = 32'h5C0F_1A01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [RIDX_W-1:0] crn,
  input  logic [RIDX_W-1:0] core_idx,
  input  logic [XLEN-1:0]   wr_data,
  output logic [NREG-1:0]   wr_en,
  output logic              rd_valid,
  output logic [XLEN-1:0]   rd_data,
  output logic [RIDX_W-1:0] rd_dest,
  output logic              tlb_flush,
  output logic              cache_flush,
  output logic [NREG-1:0][XLEN-1:0] regs
);

  localparam logic [RIDX_W-1:0] TLB_REG   = 4'd5;
  localparam logic [RIDX_W-1:0] CACHE_REG = 4'd7;

  logic            do_wr;
  logic            do_rd;
  logic [XLEN-1:0] rd_mux;

  assign do_wr = (act == ACT_WRITE);
  assign do_rd = (act == ACT_READ);

  always_comb begin
    wr_en = '0;
    if (do_wr && reg_holds(crn))
      wr_en[crn[2:0]] = 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (reg_holds(RIDX_W'(i))) begin : g_store
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en[i])
          q <= wr_data & keep_bits(RIDX_W'(i));
      end
      assign regs[i] = q;
    end else begin : g_none
      assign regs[i] = '0;
    end
  end

  always_comb begin
    if (crn == 4'd0)
      rd_mux = ID_WORD;
    else
      rd_mux = regs[crn[2:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_dest     <= '0;
      tlb_flush   <= 1'b0;
      cache_flush <= 1'b0;
    end else begin
      rd_valid    <= do_rd;
      tlb_flush   <= do_wr && (crn == TLB_REG);
      cache_flush <= do_wr && (crn == CACHE_REG);
      if (do_rd) begin
        rd_data <= rd_mux;
        rd_dest <= core_idx;
      end
    end
  end

endmodule

// File: rtl/sysctl_xfer_unit.sv
module sysctl_xfer_unit
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h5C0F_1A01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic        cond_pass,
  input  logic        priv_mode,
  input  logic [31:0] wr_data,
  output logic        accept,
  output logic        undef_trap,
  output logic [7:0]  cfg_wr_en,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [3:0]  rd_dest,
  output logic        tlb_flush,
  output logic        cache_flush,
  output logic [31:0] ctl_q,
  output logic [31:0] tbase_q,
  output logic [31:0] dom_q,
  output logic [31:0] fault_q
);

  act_e              act;
  logic [RIDX_W-1:0] crn;
  logic [RIDX_W-1:0] core_idx;
  logic [NREG-1:0][XLEN-1:0] regs;

  // Named internal events for the checker.
  logic ev_read;
  logic ev_write;
  logic ev_quiet;

  sysctl_decode u_dec (
    .insn_valid (insn_valid),
    .insn       (insn),
    .cond_pass  (cond_pass),
    .priv_mode  (priv_mode),
    .claim      (accept),
    .act        (act),
    .crn        (crn),
    .core_idx   (core_idx)
  );

  sysctl_regs #(.ID_WORD(ID_WORD)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .crn         (crn),
    .core_idx    (core_idx),
    .wr_data     (wr_data),
    .wr_en       (cfg_wr_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_dest     (rd_dest),
    .tlb_flush   (tlb_flush),
    .cache_flush (cache_flush),
    .regs        (regs)
  );

  assign undef_trap = (act == ACT_TRAP);
  assign ev_read    = (act == ACT_READ);
  assign ev_write   = (act == ACT_WRITE);
  assign ev_quiet   = (act == ACT_QUIET);

  assign ctl_q   = regs[1];
  assign tbase_q = regs[2];
  assign dom_q   = regs[3];
  assign fault_q = regs[6];

endmodule

// File: rtl/sysctl_xfer_chk.sv
module sysctl_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic        cond_pass,
  input logic        priv_mode,
  input logic        accept,
  input logic        undef_trap,
  input logic [7:0]  cfg_wr_en,
  input logic        rd_valid,
  input logic        tlb_flush,
  input logic        cache_flush,
  input logic [31:0] ctl_q,
  input logic [31:0] tbase_q,
  input logic        ev_read,
  input logic        ev_write
);

  // R1: claimed words carry the coprocessor-15 transfer shape
  a_r1_accept_shape: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (insn_valid && insn[27:24] == 4'hE && insn[11:8] == 4'hF && insn[4]));

  // R3: user mode always traps
  a_r3_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cond_pass && !priv_mode) |-> undef_trap);

  // R3: a trap never writes
  a_r3_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap |-> (cfg_wr_en == 8'h00 && !ev_write && !ev_read));

  // R4: numbers 8..15 trap
  a_r4_high_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cond_pass && insn[19]) |-> undef_trap);

  // R9: failed condition is silent
  a_r9_cond_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cond_pass) |-> (!undef_trap && cfg_wr_en == 8'h00));

  // R12: at most one write enable
  a_r12_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_wr_en));

  // R6: reserved bits stay clear
  a_r6_ctl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[31:9] == 23'h0 && tbase_q[13:0] == 14'h0));

  // R11: read result follows a privileged read one cycle later
  a_r11_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(accept && cond_pass && priv_mode && insn[20] && !undef_trap));

  // R8: strobes follow a privileged write to their register
  a_r8_tlb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(accept && cond_pass && priv_mode && !insn[20] && insn[19:16] == 4'd5));

  a_r8_cache_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cache_flush |-> $past(accept && cond_pass && priv_mode && !insn[20] && insn[19:16] == 4'd7));

endmodule

bind sysctl_xfer_unit sysctl_xfer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_valid  (insn_valid),
  .insn        (insn),
  .cond_pass   (cond_pass),
  .priv_mode   (priv_mode),
  .accept      (accept),
  .undef_trap  (undef_trap),
  .cfg_wr_en   (cfg_wr_en),
  .rd_valid    (rd_valid),
  .tlb_flush   (tlb_flush),
  .cache_flush (cache_flush),
  .ctl_q       (ctl_q),
  .tbase_q     (tbase_q),
  .ev_read     (ev_read),
  .ev_write    (ev_write)
);

// File: tb/sysctl_xfer_unit_test.sv
module sysctl_xfer_unit_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_CONST   = 32'h5C0F_1A01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        cond_pass = 1'b1;
  logic        priv_mode = 1'b1;
  logic [31:0] wr_data = '0;
  logic        accept, undef_trap, rd_valid, tlb_flush, cache_flush;
  logic [7:0]  cfg_wr_en;
  logic [31:0] rd_data, ctl_q, tbase_q, dom_q, fault_q;
  logic [3:0]  rd_dest;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_xfer_unit #(.ID_WORD(ID_CONST)) uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .cond_pass(cond_pass), .priv_mode(priv_mode), .wr_data(wr_data),
    .accept(accept), .undef_trap(undef_trap), .cfg_wr_en(cfg_wr_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_dest(rd_dest),
    .tlb_flush(tlb_flush), .cache_flush(cache_flush),
    .ctl_q(ctl_q), .tbase_q(tbase_q), .dom_q(dom_q), .fault_q(fault_q)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  // Stored bits per register, counted from the field boundaries.
  function automatic logic [31:0] kept(input int n);
    logic [31:0] m = 32'h0;
    for (int b = 0; b < 32; b++) begin
      if (n == 1 && b < 9)   m[b] = 1'b1;
      if (n == 2 && b >= 14) m[b] = 1'b1;
      if (n == 3)            m[b] = 1'b1;
      if (n == 6 && b >= 12) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] mk(input bit rd, input int crn, input int rdi,
                                     input int cp, input bit b4);
    return {4'hE, 4'hE, 3'b000, rd, 4'(crn), 4'(rdi), 4'(cp), 3'b000, b4, 4'h0};
  endfunction

  task automatic check_regs(input string req);
    check({req, " ctl"},   ctl_q,   model[1]);
    check({req, " tbase"}, tbase_q, model[2]);
    check({req, " dom"},   dom_q,   model[3]);
    check({req, " fault"}, fault_q, model[6]);
  endtask

  task automatic run_op(input logic [31:0] w, input bit cp, input bit pr, input logic [31:0] d);
    bit shape  = (w[27:24] == 4'b1110) && (w[11:8] == 4'hF) && (w[4] == 1'b1);
    int n      = int'(w[19:16]);
    bit is_rd  = w[20];
    bit live   = shape && cp;
    bit trap   = live && (!pr || n > 7);
    bit ok     = live && !trap && n != 4;
    bit do_rd  = ok && is_rd;
    bit do_wr  = ok && !is_rd;
    logic [7:0]  e_en = 8'h00;
    logic [31:0] e_rd = 32'h0;
    if (do_wr && (n == 1 || n == 2 || n == 3 || n == 6)) e_en = 8'h01 << n;
    if (do_rd) e_rd = (n == 0) ? ID_CONST : model[n];
    @(negedge clk);
    insn = w; insn_valid = 1'b1; cond_pass = cp; priv_mode = pr; wr_data = d;
    #1;
    check("R1 accept", {31'h0, accept}, {31'h0, shape});
    check(pr ? "R4 trap" : "R3 trap", {31'h0, undef_trap}, {31'h0, trap});
    check("R12 wr_en", {24'h0, cfg_wr_en}, {24'h0, e_en});
    @(negedge clk);
    insn_valid = 1'b0;
    #1;
    if (e_en != 8'h00) model[n] = d & kept(n);
    check("R11 rd_valid", {31'h0, rd_valid}, {31'h0, do_rd});
    if (do_rd) begin
      check(n == 0 ? "R7 id read" : "R6 read data", rd_data, e_rd);
      check("R11 rd_dest", {28'h0, rd_dest}, {28'h0, w[15:12]});
    end
    check("R8 tlb_flush", {31'h0, tlb_flush}, {31'h0, do_wr && n == 5});
    check("R8 cache_flush", {31'h0, cache_flush}, {31'h0, do_wr && n == 7});
    check_regs(trap ? "R3 no change" : "R6 regs");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed_dummy;
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check_regs("R10 reset");
    check("R10 rd_valid", {31'h0, rd_valid}, 32'h0);
    check("R10 strobes", {30'h0, tlb_flush, cache_flush}, 32'h0);
    rst_n = 1'b1;

    // R6 / R12: all-ones and alternating to each stored register, then read back (R2)
    foreach (model[k]) begin
      if (k < 8) begin
        run_op(mk(1'b0, k, 3, 15, 1'b1), 1'b1, 1'b1, 32'hFFFF_FFFF);
        run_op(mk(1'b1, k, 5, 15, 1'b1), 1'b1, 1'b1, 32'h0);
        run_op(mk(1'b0, k, 3, 15, 1'b1), 1'b1, 1'b1, 32'hA5A5_5A5A);
        run_op(mk(1'b1, k, 9, 15, 1'b1), 1'b1, 1'b1, 32'h0);
      end
    end
    // R7: write to register 0 ignored, read returns id
    run_op(mk(1'b0, 0, 1, 15, 1'b1), 1'b1, 1'b1, 32'h1234_5678);
    run_op(mk(1'b1, 0, 2, 15, 1'b1), 1'b1, 1'b1, 32'h0);
    // R5: register 4 silent
    run_op(mk(1'b0, 4, 1, 15, 1'b1), 1'b1, 1'b1, 32'hFFFF_FFFF);
    run_op(mk(1'b1, 4, 1, 15, 1'b1), 1'b1, 1'b1, 32'h0);
    // R3: user-mode write to register 1
    run_op(mk(1'b0, 1, 0, 15, 1'b1), 1'b1, 1'b0, 32'h0000_0000);
    // R4: privileged access to register 9 and 15
    run_op(mk(1'b1, 9, 0, 15, 1'b1), 1'b1, 1'b1, 32'h0);
    run_op(mk(1'b0, 15, 0, 15, 1'b1), 1'b1, 1'b1, 32'h0);
    // R9: failed condition write to register 3
    run_op(mk(1'b0, 3, 0, 15, 1'b1), 1'b0, 1'b1, 32'h0);
    // R1: foreign coprocessor and clear bit 4
    run_op(mk(1'b0, 3, 0, 14, 1'b1), 1'b1, 1'b1, 32'h0);
    run_op(mk(1'b0, 3, 0, 15, 1'b0), 1'b1, 1'b1, 32'h0);
    // R8: flush strobes
    run_op(mk(1'b0, 5, 0, 15, 1'b1), 1'b1, 1'b1, 32'hFFFF_FFFF);
    run_op(mk(1'b0, 7, 0, 15, 1'b1), 1'b1, 1'b1, 32'hFFFF_FFFF);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int cp  = ($urandom % 8 == 0) ? int'($urandom % 16) : 15;
      bit b4  = ($urandom % 10) != 0;
      bit pr  = ($urandom % 6) != 0;
      bit cpp = ($urandom % 9) != 0;
      run_op(mk(1'($urandom), int'($urandom % 16), int'($urandom % 16), cp, b4),
             cpp, pr, $urandom);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule